// File: doc/BRIEF.md
# DAC Update Strobe Generator

This block makes the strobe that latches new codes into the DAC converters. An update comes from one of two places. The first is an internal interval timer, which is the default. A waveform start event launches the timer, and it then issues one update every programmed number of cycles. It stops when software commands a stop or when a preloaded buffer count runs down to zero. The second is an external source: a pin chosen from a bus, on the rising or the falling edge. Updates reach the DACs only while posted-update mode is on.

Every update that reaches the DACs is also shown on a dedicated active-low pin as a pulse of fixed width. The pin driver stays tri-stated until it is enabled. If an update arrives while the echo pulse is still low, it is dropped and flagged in a sticky status bit. It does not stretch the running pulse.

Top module: `dac_update_gen`

## Requirements
- R1: While rst_ni is low and right after it rises, dac_strobe_o=0, upd_n_o=1, upd_oe_o=0 and overrun_o=0.
- R2: upd_oe_o stays 0 until pin_oe_en_i is sampled high, and then follows pin_oe_en_i one cycle later.
- R3: With src_ext_i=1, the selected edge of pin_i[pin_sel_i] (pol_i=0 rising, pol_i=1 falling) gives exactly one dac_strobe_o cycle, 3 cycles after the cycle in which the pin changed. The opposite edge and edges on other pins give no strobe.
- R4: With src_ext_i=0, a start_i pulse launches the interval timer. Let P = max(interval_i, 4). The first strobe comes P+1 cycles after the start cycle, and the next strobes follow every P cycles.
- R5: start_i has no effect while src_ext_i=1.
- R6: A nonzero buf_cnt_i sampled with start_i allows exactly that many internal updates, after which the timer stops. A value of 0 means no limit.
- R7: sw_stop_i halts the timer. An update due in the same cycle as sw_stop_i is suppressed.
- R8: With posted_i=0, no strobe is issued and upd_n_o stays high.
- R9: upd_n_o falls in the same cycle as each dac_strobe_o and stays low for exactly 2 cycles.
- R10: An update that arrives while upd_n_o is low is dropped. It gives no strobe and does not extend the pulse. It sets overrun_o, which holds until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (40 MHz nominal) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Waveform start event, one-cycle pulse |
| pin_i | input | N_PIN | External pin bus (asynchronous) |
| pin_sel_i | input | $clog2(N_PIN) | Index of the external source pin |
| pol_i | input | 1 | Edge polarity: 0 rising, 1 falling |
| src_ext_i | input | 1 | 1 selects the external pin, 0 the internal timer |
| interval_i | input | CNT_W | Update period in cycles (minimum 4) |
| buf_cnt_i | input | CNT_W | Updates allowed per run, 0 = unlimited |
| sw_stop_i | input | 1 | Software stop for the timer |
| posted_i | input | 1 | Posted-update mode enable |
| pin_oe_en_i | input | 1 | Enable for the echo pin driver |
| dac_strobe_o | output | 1 | DAC latch strobe, one cycle |
| upd_n_o | output | 1 | Echo pulse level, active low |
| upd_oe_o | output | 1 | Echo pin output enable |
| overrun_o | output | 1 | Sticky flag: an update was dropped |

## Verification
Two pairs of events can land in the same cycle. The first pair is an internal timer expiry and a software stop. The bench drives sw_stop_i in exactly the cycle in which the timer reaches zero. It then expects no strobe in the following cycle and no strobe for a long time after. The second pair is a new external edge and the low phase of the previous echo pulse. The bench puts two rising edges of the selected pin two cycles apart. It expects one strobe, a low pulse of exactly two cycles, and overrun_o set and held.

// File: rtl/dac_upd_pkg.sv
package dac_upd_pkg;
  localparam int unsigned MIN_PERIOD = 4;
  typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_pol_e;
endpackage

// File: rtl/dac_upd_edge_sel.sv
module dac_upd_edge_sel #(
  parameter int unsigned N_PIN       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned SEL_W      = (N_PIN > 1) ? $clog2(N_PIN) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_PIN-1:0] pin_i,
  input  logic [SEL_W-1:0] pin_sel_i,
  input  dac_upd_pkg::edge_pol_e pol_i,
  output logic             edge_o
);
  logic [N_PIN-1:0] sync_q [SYNC_STAGES];
  logic             lvl, prev_q;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[s] <= '0;
      else if (s == 0) sync_q[s] <= pin_i;
      else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
    end
  end

  // Polarity folded in so that one rising detector covers both edges.
  assign lvl = sync_q[SYNC_STAGES-1][pin_sel_i] ^ (pol_i == dac_upd_pkg::EDGE_FALL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else prev_q <= lvl;
  end

  assign edge_o = lvl & ~prev_q;

  // R3
  edge_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o);
endmodule

// File: rtl/dac_upd_timer.sv
module dac_upd_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             fire_i,
  input  logic [CNT_W-1:0] interval_i,
  input  logic [CNT_W-1:0] buf_cnt_i,
  output logic             tick_o
);
  localparam logic [CNT_W-1:0] MIN_P = CNT_W'(dac_upd_pkg::MIN_PERIOD);

  logic [CNT_W-1:0] period, cnt_q, remain_q;
  logic             running_q;

  assign period = (interval_i < MIN_P) ? MIN_P : interval_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      cnt_q     <= '0;
      remain_q  <= '0;
    end else if (stop_i) begin
      running_q <= 1'b0;
    end else if (start_i) begin
      running_q <= 1'b1;
      cnt_q     <= period - CNT_W'(1);
      remain_q  <= buf_cnt_i;
    end else if (running_q) begin
      if (cnt_q == '0) begin
        cnt_q <= period - CNT_W'(1);
        if (fire_i && remain_q == CNT_W'(1)) running_q <= 1'b0;
        if (fire_i && remain_q != '0) remain_q <= remain_q - CNT_W'(1);
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  // A stop in the expiry cycle wins over the update.
  assign tick_o = running_q & (cnt_q == '0) & ~stop_i;

  // R7
  stop_halts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !tick_o);
  // R6
  buf_exhaust_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && remain_q == CNT_W'(1) && !start_i) |=> !running_q);
endmodule

// File: rtl/dac_upd_pulse.sv
module dac_upd_pulse #(
  parameter int unsigned PULSE_CYC = 2,
  localparam int unsigned PW_W     = $clog2(PULSE_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic strobe_o,
  output logic pin_n_o,
  output logic overrun_o
);
  logic [PW_W-1:0] pw_q;
  logic            busy, accept;

  assign busy   = (pw_q != '0);
  assign accept = fire_i & ~busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pw_q      <= '0;
      strobe_o  <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      strobe_o <= accept;
      if (accept) pw_q <= PW_W'(PULSE_CYC);
      else if (busy) pw_q <= pw_q - PW_W'(1);
      if (fire_i && busy) overrun_o <= 1'b1;
    end
  end

  assign pin_n_o = ~busy;

  // R9
  strobe_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> !pin_n_o);
  // R9
  fall_has_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pin_n_o) |-> strobe_o);
  // R10
  overrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);
endmodule

// File: rtl/dac_update_gen.sv
module dac_update_gen #(
  parameter int unsigned N_PIN       = 8,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned PULSE_CYC   = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned SEL_W      = (N_PIN > 1) ? $clog2(N_PIN) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [N_PIN-1:0] pin_i,
  input  logic [SEL_W-1:0] pin_sel_i,
  input  logic             pol_i,
  input  logic             src_ext_i,
  input  logic [CNT_W-1:0] interval_i,
  input  logic [CNT_W-1:0] buf_cnt_i,
  input  logic             sw_stop_i,
  input  logic             posted_i,
  input  logic             pin_oe_en_i,
  output logic             dac_strobe_o,
  output logic             upd_n_o,
  output logic             upd_oe_o,
  output logic             overrun_o
);
  logic ext_edge, int_tick, int_fire, upd_fire;

  dac_upd_edge_sel #(.N_PIN(N_PIN), .SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i, .rst_ni, .pin_i, .pin_sel_i,
    .pol_i (dac_upd_pkg::edge_pol_e'(pol_i)),
    .edge_o(ext_edge)
  );

  assign int_fire = int_tick & posted_i;

  dac_upd_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni,
    .start_i   (start_i & ~src_ext_i),
    .stop_i    (sw_stop_i),
    .fire_i    (int_fire),
    .interval_i, .buf_cnt_i,
    .tick_o    (int_tick)
  );

  assign upd_fire = posted_i & (src_ext_i ? ext_edge : int_tick);

  dac_upd_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk_i, .rst_ni,
    .fire_i   (upd_fire),
    .strobe_o (dac_strobe_o),
    .pin_n_o  (upd_n_o),
    .overrun_o(overrun_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upd_oe_o <= 1'b0;
    else upd_oe_o <= pin_oe_en_i;
  end

  // R8
  no_posted_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !posted_i |=> !dac_strobe_o);
endmodule

// File: tb/tb_dac_update_gen.sv
module tb_dac_update_gen;
  localparam int N_PIN = 8;
  localparam int CNT_W = 16;
  localparam time CLK_PERIOD = 25ns;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 0, pol_i = 0, src_ext_i = 0, sw_stop_i = 0, posted_i = 0, pin_oe_en_i = 0;
  logic [N_PIN-1:0] pin_i = '0;
  logic [2:0] pin_sel_i = '0;
  logic [CNT_W-1:0] interval_i = 16'd4, buf_cnt_i = '0;
  logic dac_strobe_o, upd_n_o, upd_oe_o, overrun_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_update_gen dut (
    .clk_i(clk), .rst_ni, .start_i, .pin_i, .pin_sel_i, .pol_i, .src_ext_i,
    .interval_i, .buf_cnt_i, .sw_stop_i, .posted_i, .pin_oe_en_i,
    .dac_strobe_o, .upd_n_o, .upd_oe_o, .overrun_o
  );

  function automatic int exp_period(int iv);
    return (iv < 4) ? 4 : iv;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Counts strobes and low pin cycles over n negedges; first/second strobe index.
  task automatic watch(int n, output int cnt, output int first, output int second, output int lows);
    cnt = 0; first = -1; second = -1; lows = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (!upd_n_o) lows++;
      if (dac_strobe_o) begin
        cnt++;
        if (first < 0) first = i;
        else if (second < 0) second = i;
      end
    end
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    fork begin @(negedge clk); start_i = 1'b0; end join_none
  endtask

  task automatic pulse_stop();
    sw_stop_i = 1'b1;
    @(negedge clk);
    sw_stop_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c, f, s, l, p, b, sel, other;
    bit pl;
    void'($urandom(32'h5eed));
    cyc(2);
    // R1 during reset
    chk(!dac_strobe_o && upd_n_o && !upd_oe_o && !overrun_o, "R1 in reset",
        {dac_strobe_o, upd_n_o, upd_oe_o, overrun_o}, 4'b0100);
    rst_ni = 1'b1;
    cyc(1);
    chk(!dac_strobe_o && upd_n_o && !upd_oe_o && !overrun_o, "R1 after reset",
        {dac_strobe_o, upd_n_o, upd_oe_o, overrun_o}, 4'b0100);

    // R2 output enable
    cyc(3);
    chk(upd_oe_o == 1'b0, "R2 idle", upd_oe_o, 0);
    pin_oe_en_i = 1'b1;
    cyc(1);
    chk(upd_oe_o == 1'b1, "R2 enabled", upd_oe_o, 1);

    // R4 R6 R9 internal, buffer of 3
    posted_i = 1'b1; interval_i = 16'd6; buf_cnt_i = 16'd3;
    pulse_start();
    watch(40, c, f, s, l);
    chk(f == 7, "R4 first", f, 7);
    chk(s - f == 6, "R4 spacing", s - f, 6);
    chk(c == 3, "R6 buffer count", c, 3);
    chk(l == 6, "R9 low cycles", l, 6);

    // R4 clamp to minimum period
    interval_i = 16'd1; buf_cnt_i = 16'd2;
    pulse_start();
    watch(20, c, f, s, l);
    chk(f == 5 && s == 9, "R4 clamp", f * 100 + s, 509);

    // random internal runs
    for (int t = 0; t < 4; t++) begin
      p = 1 + ($urandom % 9); b = 1 + ($urandom % 4);
      interval_i = CNT_W'(p); buf_cnt_i = CNT_W'(b);
      pulse_start();
      watch(exp_period(p) * (b + 1) + 4, c, f, s, l);
      chk(f == exp_period(p) + 1, "R4 random first", f, exp_period(p) + 1);
      chk(c == b, "R6 random count", c, b);
    end

    // R7 unlimited run then stop
    interval_i = 16'd5; buf_cnt_i = '0;
    pulse_start();
    watch(16, c, f, s, l);
    chk(c == 3, "R6 unlimited", c, 3);
    pulse_stop();
    watch(30, c, f, s, l);
    chk(c == 0, "R7 stopped", c, 0);

    // R7 stop in the expiry cycle
    pulse_start();
    cyc(5);
    sw_stop_i = 1'b1;
    @(negedge clk);
    chk(!dac_strobe_o && upd_n_o, "R7 collide", dac_strobe_o, 0);
    sw_stop_i = 1'b0;
    watch(20, c, f, s, l);
    chk(c == 0, "R7 collide after", c, 0);

    // R8 posted off
    posted_i = 1'b0; interval_i = 16'd4;
    pulse_start();
    watch(20, c, f, s, l);
    chk(c == 0 && l == 0, "R8 no posted", c + l, 0);
    pulse_stop();
    posted_i = 1'b1;

    // R5 start ignored in external mode
    src_ext_i = 1'b1;
    cyc(3);
    pulse_start();
    watch(20, c, f, s, l);
    chk(c == 0, "R5 start ignored", c, 0);

    // R3 random external edges
    for (int t = 0; t < 16; t++) begin
      src_ext_i = 1'b0; pin_i = '0;
      sel = $urandom % N_PIN; pl = 1'($urandom % 2);
      other = (sel + 1) % N_PIN;
      pin_sel_i = 3'(sel); pol_i = pl;
      cyc(4);
      src_ext_i = 1'b1;
      cyc(2);
      pin_i[other] = 1'b1;
      watch(6, c, f, s, l);
      pin_i[other] = 1'b0;
      watch(6, c, f, s, l);
      chk(c == 0, "R3 other pin", c, 0);
      pin_i[sel] = 1'b1;
      watch(6, c, f, s, l);
      if (!pl) begin
        chk(c == 1 && f == 3, "R3 rising", f, 3);
      end else begin
        chk(c == 0, "R3 rise ignored", c, 0);
        pin_i[sel] = 1'b0;
        watch(6, c, f, s, l);
        chk(c == 1 && f == 3, "R3 falling", f, 3);
      end
    end

    // R10 overrun
    src_ext_i = 1'b0; pin_i = '0; pin_sel_i = '0; pol_i = 1'b0;
    cyc(4);
    src_ext_i = 1'b1;
    cyc(2);
    chk(overrun_o == 1'b0, "R10 clear", overrun_o, 0);
    pin_i[0] = 1'b1;
    @(negedge clk); pin_i[0] = 1'b0;
    @(negedge clk); pin_i[0] = 1'b1;
    watch(10, c, f, s, l);
    chk(c == 1, "R10 dropped", c, 1);
    chk(l == 2, "R10 not extended", l, 2);
    chk(overrun_o == 1'b1, "R10 set", overrun_o, 1);
    cyc(10);
    chk(overrun_o == 1'b1, "R10 held", overrun_o, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule